// File: doc/BRIEF.md
# Line Bit-Error-Rate Window Monitor

This block watches the stream of received 5-bit code groups on a 100 Mb/s link and counts how many of them fall outside the set of legal code groups. Errors are tallied inside a time window whose length is chosen by a 4-bit exponential code. At the close of every window the tally restarts, so the count always describes the current window only.

The count is compared against a programmable trigger level. A small link-quality state machine reports a good link once the count sits below that level. When the count climbs to the level, the machine enters a degraded state. In that state it can set a sticky interrupt flag and, if allowed, request that the link be taken down. The degraded state is released only when the window closes.

The window is timed by a prescaler on the local clock. With the default divide of 1250 cycles at 125 MHz, one base tick is 0.01 ms. Code n (1 to 14) spans 2^(n-1) base ticks, which is 0.005 × 2^n ms. Code 15 keeps the window open without end. Code 0 switches every counting function off.

Top module: `ber_window_monitor`

## Requirements
- R1: A symbol is counted as an error only in a cycle where `sym_valid` and `sym_bad` are both 1. Each such cycle adds exactly 1 to `err_count`, visible after the same clock edge. A valid good symbol, or a bad flag without valid, leaves the count unchanged.
- R2: With a window code n in 1..14, the window lasts TICK_DIV × 2^(n-1) cycles, counted from the edge that writes the code. At the last edge of the window, `err_count` returns to 0. A bad symbol sampled at that same edge is counted as 1 in the new window.
- R3: `err_count` saturates at 2^CNT_W − 1 and never wraps.
- R4: Code 15 never closes the window, so the count is never cleared by time.
- R5: While the stored code is 0, `err_count` stays 0, bad symbols are ignored, `link_good` is 0, and neither the interrupt flag nor `link_down_req` can set.
- R6: Every write through `code_we` has the same effect, whatever the code value. After that edge, `err_count` is 0, the window restarts, and the link-quality machine returns to its start state.
- R7: From the start state, `link_good` rises one edge after a cycle in which counting is enabled and `err_count` < `threshold`.
- R8: In the cycle where `err_count` ≥ `threshold` with counting enabled, the machine moves to the degraded state at the next edge. From that edge, `link_good` is 0, and `link_down_req` is 1 when `linkdown_en` is 1.
- R9: The degraded state holds until a window boundary. There it returns to the start state, with `link_good` 0 and `link_down_req` 0. `link_good` comes back one edge later.
- R10: `irq_flag` sets at the edge that enters the degraded state if `irq_en` is 1. It stays set until a cycle with `irq_clr` = 1, which clears it at the next edge. A set event in the same cycle wins over the clear.
- R11: With `linkdown_en` = 0, `link_down_req` stays 0 through the degraded state. With `irq_en` = 0, `irq_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | A decoded code group is present this cycle |
| sym_bad | input | 1 | The present code group is not a legal one |
| code_in | input | 4 | Window code to store |
| code_we | input | 1 | Store `code_in` and restart counting |
| threshold | input | CNT_W | Trigger level for the error count |
| irq_en | input | 1 | Allow the interrupt flag to set |
| linkdown_en | input | 1 | Allow the link-down request |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq_flag` |
| err_count | output | CNT_W | Errors seen in the current window |
| link_good | output | 1 | Link-quality machine is in its good state |
| irq_flag | output | 1 | Sticky trigger interrupt |
| link_down_req | output | 1 | Request to force the link down |

## Verification
`err_count` is a single register stage. It is checked at the falling edge after the rising edge that sampled the symbol, or after the rising edge that wrote the code. The state outputs `link_good`, `link_down_req` and `irq_flag` sit one register later, so the bench first checks that they have not yet moved when the count reaches the trigger level, and only then checks the new values one edge on. Window boundaries are checked on both sides: one edge before TICK_DIV × 2^(n-1), where the count must still stand, and at that edge, where it must be 0. The bench uses a small TICK_DIV so that these edges stay few in number.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;

   localparam int CODE_W    = 4;
   localparam int CODE_OFF  = 0;
   localparam int CODE_FREE = 15;
   localparam int CODE_MAXB = 14;          // largest bounded code
   localparam int WIN_W     = CODE_MAXB - 1; // ticks counter width

   typedef enum logic [1:0] {
      LQ_START = 2'd0,
      LQ_GOOD  = 2'd1,
      LQ_BAD   = 2'd2
   } lq_state_t;

   // Last tick index of a bounded window: 2^(code-1) - 1
   function automatic logic [WIN_W-1:0] win_last(input logic [CODE_W-1:0] code);
      logic [WIN_W-1:0] v;
      for (int i = 0; i < WIN_W; i++)
         v[i] = ((i + 1) < int'(code));
      return v;
   endfunction

endpackage

// File: rtl/ber_window_timer.sv
module ber_window_timer
   import ber_mon_pkg::*;
#(
   parameter int TICK_DIV = 1250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              win_end
);

   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("ber_window_timer: TICK_DIV must be at least 1");
      end
   endgenerate

   logic              en;
   logic              bounded;
   logic              tick;
   logic [WIN_W-1:0]  win_ticks;
   logic [WIN_W-1:0]  last_tick;

   assign en        = (code != CODE_W'(CODE_OFF));
   assign bounded   = en && (code != CODE_W'(CODE_FREE));
   assign last_tick = win_last(code);

   generate
      if (TICK_DIV == 1) begin : g_no_pre
         assign tick = en;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_cnt <= '0;
            else if (restart || !en)
               pre_cnt <= '0;
            else if (pre_cnt == PRE_W'(TICK_DIV - 1))
               pre_cnt <= '0;
            else
               pre_cnt <= pre_cnt + 1'b1;
         end
         assign tick = en && (pre_cnt == PRE_W'(TICK_DIV - 1));

         assert_prescale_range_R2 : assert property (
            @(posedge clk) disable iff (!rst_n)
            32'(pre_cnt) < TICK_DIV);
      end
   endgenerate

   assign win_end = tick && bounded && !restart && (win_ticks == last_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_ticks <= '0;
      else if (restart || !en)
         win_ticks <= '0;
      else if (tick)
         win_ticks <= win_end ? '0 : win_ticks + 1'b1;
   end

   // R4: an unbounded code never closes the window
   assert_free_never_ends_R4 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (code == CODE_W'(CODE_FREE)) |-> !win_end);

endmodule

// File: rtl/ber_err_counter.sv
module ber_err_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic             win_end,
   input  logic             hit,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("ber_err_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (restart || !en)
         count <= '0;
      else if (win_end)
         count <= hit ? CNT_W'(1) : '0;
      else if (hit && (count != CNT_MAX))
         count <= count + 1'b1;
   end

   assert_count_no_wrap_R3 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !restart && !win_end && en) |=> (count == CNT_MAX));

   assert_disabled_zero_R5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      !en |=> (count == '0));

endmodule

// File: rtl/ber_link_fsm.sv
module ber_link_fsm
   import ber_mon_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic             win_end,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] threshold,
   input  logic             irq_en,
   input  logic             irq_clr,
   input  logic             linkdown_en,
   output logic             link_good,
   output logic             irq_flag,
   output logic             link_down_req
);

   lq_state_t state, state_nx;
   logic      over;
   logic      enter_bad;

   assign over = (count >= threshold);

   always_comb begin
      state_nx = state;
      if (restart || !en)
         state_nx = LQ_START;
      else if (state != LQ_BAD && over)
         state_nx = LQ_BAD;
      else if (state == LQ_BAD && win_end)
         state_nx = LQ_START;
      else if (state == LQ_START && !over)
         state_nx = LQ_GOOD;
   end

   assign enter_bad = (state_nx == LQ_BAD) && (state != LQ_BAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= LQ_START;
      else
         state <= state_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_flag <= 1'b0;
      else if (enter_bad && irq_en)
         irq_flag <= 1'b1;
      else if (irq_clr)
         irq_flag <= 1'b0;
   end

   assign link_good     = (state == LQ_GOOD);
   assign link_down_req = linkdown_en && (state == LQ_BAD);

   assert_bad_holds_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (state == LQ_BAD && en && !restart && !win_end) |=> (state == LQ_BAD));

   assert_irq_sticky_R10 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

endmodule

// File: rtl/ber_window_monitor.sv
module ber_window_monitor
   import ber_mon_pkg::*;
#(
   parameter int TICK_DIV = 1250,
   parameter int CNT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic             sym_bad,
   input  logic [3:0]       code_in,
   input  logic             code_we,
   input  logic [CNT_W-1:0] threshold,
   input  logic             irq_en,
   input  logic             linkdown_en,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] err_count,
   output logic             link_good,
   output logic             irq_flag,
   output logic             link_down_req
);

   logic [CODE_W-1:0] code_q;
   logic              en;
   logic              win_end;
   logic              hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= CODE_W'(CODE_OFF);
      else if (code_we)
         code_q <= code_in;
   end

   assign en  = (code_q != CODE_W'(CODE_OFF));
   assign hit = sym_valid && sym_bad;

   ber_window_timer #(
      .TICK_DIV (TICK_DIV)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (code_we),
      .code    (code_q),
      .win_end (win_end)
   );

   ber_err_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .restart (code_we),
      .win_end (win_end),
      .hit     (hit),
      .count   (err_count)
   );

   ber_link_fsm #(
      .CNT_W (CNT_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .restart       (code_we),
      .win_end       (win_end),
      .count         (err_count),
      .threshold     (threshold),
      .irq_en        (irq_en),
      .irq_clr       (irq_clr),
      .linkdown_en   (linkdown_en),
      .link_good     (link_good),
      .irq_flag      (irq_flag),
      .link_down_req (link_down_req)
   );

   assert_trigger_drops_good_R8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (en && !code_we && err_count >= threshold) |=> !link_good);

   assert_restart_clears_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      code_we |=> (err_count == '0));

endmodule

// File: tb/ber_window_monitor_test.sv
`timescale 1ns/1ps
module ber_window_monitor_test;

   localparam int DIV = 4;
   localparam int CW  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sym_valid = 1'b0;
   logic          sym_bad = 1'b0;
   logic [3:0]    code_in = 4'd0;
   logic          code_we = 1'b0;
   logic [CW-1:0] threshold = '1;
   logic          irq_en = 1'b0;
   logic          linkdown_en = 1'b0;
   logic          irq_clr = 1'b0;
   logic [CW-1:0] err_count;
   logic          link_good;
   logic          irq_flag;
   logic          link_down_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ber_window_monitor #(.TICK_DIV(DIV), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bad(sym_bad),
      .code_in(code_in), .code_we(code_we), .threshold(threshold),
      .irq_en(irq_en), .linkdown_en(linkdown_en), .irq_clr(irq_clr),
      .err_count(err_count), .link_good(link_good), .irq_flag(irq_flag),
      .link_down_req(link_down_req));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_code(input logic [3:0] c);
      @(negedge clk);
      code_in = c;
      code_we = 1'b1;
      @(negedge clk);
      code_we = 1'b0;
   endtask

   task automatic sym(input logic v, input logic b);
      sym_valid = v;
      sym_bad   = b;
      @(negedge clk);
      sym_valid = 1'b0;
      sym_bad   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R5 reset count", int'(err_count), 0);
      check("R5 reset link_good", int'(link_good), 0);
      check("R10 reset irq", int'(irq_flag), 0);
      check("R8 reset link_down", int'(link_down_req), 0);
   endtask

   task automatic t_count_patterns;
      threshold = 6'd40;
      write_code(4'd15);
      idle(1);
      check("R7 good after enable", int'(link_good), 1);
      sym(1, 1);
      check("R1 first error", int'(err_count), 1);
      sym(1, 0);
      sym(0, 1);
      check("R1 non-errors ignored", int'(err_count), 1);
      sym(1, 1);
      sym(1, 1);
      check("R1 two more errors", int'(err_count), 3);
      idle(150);
      check("R4 free window keeps count", int'(err_count), 3);
      write_code(4'd15);
      check("R6 rewrite clears count", int'(err_count), 0);
      check("R6 rewrite returns to start", int'(link_good), 0);
   endtask

   task automatic t_window(input logic [3:0] c, input int len);
      threshold = 6'd40;
      write_code(c);
      sym(1, 1);
      idle(len - 2);
      check($sformatf("R2 code %0d count before end", c), int'(err_count), 1);
      idle(1);
      check($sformatf("R2 code %0d cleared at end", c), int'(err_count), 0);
   endtask

   task automatic t_boundary_hit;
      threshold = 6'd40;
      write_code(4'd1);
      idle(DIV - 1);
      sym(1, 1);
      check("R2 boundary error counted in new window", int'(err_count), 1);
   endtask

   task automatic t_saturate;
      threshold = '1;
      write_code(4'd15);
      for (int i = 0; i < 70; i++) sym(1, 1);
      check("R3 saturated", int'(err_count), 63);
   endtask

   task automatic t_trigger;
      threshold   = 6'd3;
      irq_en      = 1'b1;
      linkdown_en = 1'b1;
      write_code(4'd15);
      idle(1);
      sym(1, 1);
      sym(1, 1);
      check("R7 good under level", int'(link_good), 1);
      sym(1, 1);
      check("R8 count at level", int'(err_count), 3);
      check("R8 state one edge later", int'(link_good), 1);
      idle(1);
      check("R8 good dropped", int'(link_good), 0);
      check("R8 link down request", int'(link_down_req), 1);
      check("R10 irq set", int'(irq_flag), 1);
      idle(3);
      check("R10 irq held", int'(irq_flag), 1);
      irq_clr = 1'b1;
      idle(1);
      irq_clr = 1'b0;
      check("R10 irq cleared", int'(irq_flag), 0);
      check("R9 bad held in free window", int'(link_down_req), 1);
      irq_en = 1'b0;
   endtask

   task automatic t_release;
      threshold   = 6'd2;
      linkdown_en = 1'b1;
      write_code(4'd1);
      sym(1, 1);
      sym(1, 1);
      check("R8 count reached 2", int'(err_count), 2);
      idle(1);
      check("R8 link down in window", int'(link_down_req), 1);
      idle(1);
      check("R9 released at boundary", int'(link_down_req), 0);
      check("R9 start state not good", int'(link_good), 0);
      check("R2 count cleared", int'(err_count), 0);
      idle(1);
      check("R9 good one edge later", int'(link_good), 1);
   endtask

   task automatic t_disabled_outputs;
      threshold   = 6'd1;
      irq_en      = 1'b0;
      linkdown_en = 1'b0;
      write_code(4'd15);
      idle(1);
      sym(1, 1);
      idle(1);
      check("R11 degraded state reached", int'(link_good), 0);
      check("R11 no link down", int'(link_down_req), 0);
      check("R11 no irq", int'(irq_flag), 0);
   endtask

   task automatic t_code_zero;
      threshold   = 6'd1;
      irq_en      = 1'b1;
      linkdown_en = 1'b1;
      write_code(4'd15);
      sym(1, 1);
      write_code(4'd0);
      check("R5 write zero clears", int'(err_count), 0);
      for (int i = 0; i < 5; i++) sym(1, 1);
      check("R5 errors ignored", int'(err_count), 0);
      check("R5 link_good low", int'(link_good), 0);
      check("R5 no link down", int'(link_down_req), 0);
      irq_clr = 1'b1;
      idle(1);
      irq_clr = 1'b0;
      idle(3);
      check("R5 no irq", int'(irq_flag), 0);
      irq_en      = 1'b0;
      linkdown_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_count_patterns();
      t_window(4'd1, DIV);
      t_window(4'd2, DIV * 2);
      t_window(4'd3, DIV * 4);
      t_window(4'd5, DIV * 16);
      t_boundary_hit();
      t_saturate();
      t_trigger();
      t_release();
      t_disabled_outputs();
      t_code_zero();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule